// File: doc/BRIEF.md
# Branch Target Buffer Predictor with Dual Prefetch Queues

This block guesses the outcome of jump and call instructions for a fetch unit that fills one of two alternating prefetch queues. The decode stage presents the address of a control-transfer instruction. In the same cycle the block answers with a hit flag, a taken/not-taken guess and a predicted destination. A taken guess switches fetch over to the idle queue. That queue is emptied and starts filling from the predicted destination, while the queue that was active keeps its bytes.

When a branch resolves further down the pipe, the block receives the real outcome and destination, along with the guess made earlier. It trains a direct-mapped table of 256 entries. Each entry holds a valid bit, an address tag, a 2-bit saturating confidence counter and a destination. The block compares the real outcome with the guess. On a mismatch it empties both queues and restarts fetch at the correct address. Fetch traffic leaves through a simple request port that carries an address, the queue it fills and a ready handshake.

Top module: `btb_predictor`

## Requirements
- R1: A synchronous active-high reset invalidates every table entry, selects queue 0, empties both queues and points queue 0's fetch address at RESET_ADDR (default 0x1000).
- R2: A lookup whose entry is invalid, or whose tag (address bits [31:8]) differs, returns hit=0 and taken=0. The index is address bits [7:0].
- R3: A taken resolution of an address that misses allocates its entry with the counter at weak-taken (2) and the resolved destination. A following lookup then returns hit=1, taken=1 and that destination.
- R4: On a hit, each resolution steps the 2-bit counter by one toward its outcome (taken +1, not taken -1), saturating at 0 and 3. The guess is taken when the counter is 2 or 3.
- R5: The table is direct-mapped. A taken resolution at an address that aliases an existing entry's index replaces that entry, so the old address then misses.
- R6: When a resolution and a lookup address the same entry in the same cycle, the lookup returns the entry as updated by that resolution.
- R7: A taken guess makes the other queue active at the next edge. That queue is emptied and its fetch address becomes the predicted destination. The previously active queue keeps its fill level.
- R8: A resolution mispredicts when the outcome differs from the guess, or when both are taken and the destinations differ. The mispredict output is asserted in that cycle. At the next edge both queues are empty and the active queue fetches from the destination (taken) or the next sequential address (not taken). A mispredict overrides a taken guess in the same cycle, and the active queue does not change.
- R9: A fetch request is raised while the active queue holds at most QUEUE_BYTES-FETCH_BYTES (32-8) bytes. Each accepted request adds FETCH_BYTES to that queue's level and to its fetch address, so a level never exceeds 32.
- R10: A decode take removes FETCH_BYTES from the active queue when it holds at least that many. A take and an accepted request in the same cycle leave the level unchanged.
- R11: A not-taken resolution of an address that misses leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Decode-stage lookup strobe |
| lk_pc | input | 32 | Address of the branch being looked up |
| pred_hit | output | 1 | Lookup matched a valid entry |
| pred_taken | output | 1 | Guess: branch taken |
| pred_target | output | 32 | Predicted destination (0 on a miss) |
| upd_valid | input | 1 | Resolution strobe |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome |
| upd_target | input | 32 | Real destination |
| upd_next_pc | input | 32 | Sequential address after the branch |
| upd_pred_taken | input | 1 | Guess that was made for this branch |
| upd_pred_target | input | 32 | Destination that was guessed |
| mispredict | output | 1 | Resolution disagrees with its guess |
| dec_take | input | 1 | Decode consumes one chunk from the active queue |
| fetch_req_valid | output | 1 | Fetch request for the active queue |
| fetch_req_ready | input | 1 | Memory side accepts the request |
| fetch_req_addr | output | 32 | Fetch address of the active queue |
| fetch_req_q | output | 1 | Queue the request fills |
| active_q | output | 1 | Currently active queue |
| q0_level | output | 6 | Bytes held in queue 0 |
| q1_level | output | 6 | Bytes held in queue 1 |

## Verification
Assertions check on every cycle that each queue's level stays within its capacity and that a mispredict empties both queues without changing the active queue. They also check that a lone taken guess swaps the active queue, that an accepted request advances the fetch address by one chunk, and that resolutions move a counter only toward their outcome, allocate on a taken miss and leave the table alone on a not-taken miss. Only the directed scenarios can show the full counter walk with its saturation points, the eviction of an aliasing entry, the same-cycle forwarding of a resolution into a lookup, and the exact restart addresses after a redirect.

// File: rtl/btbp_pkg.sv
package btbp_pkg;

    localparam int ADDR_W  = 32;
    localparam int IDX_W   = 8;
    localparam int ENTRIES = 1 << IDX_W;
    localparam int TAG_W   = ADDR_W - IDX_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [TAG_W-1:0]  tag_t;

    typedef enum logic [1:0] {
        CTR_SNT = 2'd0,
        CTR_WNT = 2'd1,
        CTR_WT  = 2'd2,
        CTR_ST  = 2'd3
    } ctr_e;

    typedef struct packed {
        logic  valid;
        tag_t  tag;
        ctr_e  ctr;
        addr_t target;
    } entry_t;

    typedef struct packed {
        logic  hit;
        logic  taken;
        addr_t target;
    } pred_t;

    typedef struct packed {
        logic  valid;
        addr_t pc;
        logic  taken;
        addr_t target;
        addr_t next_pc;
        logic  pred_taken;
        addr_t pred_target;
    } resolve_t;

    function automatic idx_t idx_of(input addr_t a);
        return a[IDX_W-1:0];
    endfunction

    function automatic tag_t tag_of(input addr_t a);
        return a[ADDR_W-1:IDX_W];
    endfunction

    function automatic ctr_e ctr_step(input ctr_e c, input logic taken);
        ctr_e r;
        r = c;
        if (taken) begin
            if (c != CTR_ST) r = ctr_e'(c + 2'd1);
        end else begin
            if (c != CTR_SNT) r = ctr_e'(c - 2'd1);
        end
        return r;
    endfunction

    function automatic logic ctr_says_taken(input ctr_e c);
        return (c == CTR_WT) || (c == CTR_ST);
    endfunction

endpackage

// File: rtl/btbp_table.sv
module btbp_table
    import btbp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     lk_valid,
    input  addr_t    lk_pc,
    output pred_t    pred,
    input  resolve_t res
);

    entry_t mem [ENTRIES];

    idx_t   u_idx;
    entry_t u_old;
    entry_t u_new;
    logic   u_hit;
    logic   u_we;

    idx_t   l_idx;
    entry_t l_ent;

    assign u_idx = idx_of(res.pc);
    assign u_old = mem[u_idx];
    assign u_hit = u_old.valid && (u_old.tag == tag_of(res.pc));

    // Training: step the counter on a hit, allocate on a taken miss.
    always_comb begin
        u_new = u_old;
        u_we  = 1'b0;
        if (res.valid) begin
            if (u_hit) begin
                u_we      = 1'b1;
                u_new.ctr = ctr_step(u_old.ctr, res.taken);
                if (res.taken) u_new.target = res.target;
            end else if (res.taken) begin
                u_we         = 1'b1;
                u_new.valid  = 1'b1;
                u_new.tag    = tag_of(res.pc);
                u_new.ctr    = CTR_WT;
                u_new.target = res.target;
            end
        end
    end

    // Lookup sees the entry being written this cycle (update wins).
    assign l_idx = idx_of(lk_pc);
    assign l_ent = (u_we && (u_idx == l_idx)) ? u_new : mem[l_idx];

    always_comb begin
        pred.hit    = lk_valid && l_ent.valid && (l_ent.tag == tag_of(lk_pc));
        pred.taken  = pred.hit && ctr_says_taken(l_ent.ctr);
        pred.target = pred.hit ? l_ent.target : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) mem[i].valid <= 1'b0;
        end else if (u_we) begin
            mem[u_idx] <= u_new;
        end
    end

    AST_ALLOC_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (res.valid && res.taken) |=> (mem[$past(u_idx)].valid &&
                                      mem[$past(u_idx)].tag == $past(tag_of(res.pc)))); // R3

    AST_NT_MISS_KEEP: assert property (@(posedge clk) disable iff (rst)
        (res.valid && !res.taken && !u_hit) |=> (mem[$past(u_idx)] == $past(u_old))); // R11

    AST_CTR_UP: assert property (@(posedge clk) disable iff (rst)
        (res.valid && u_hit && res.taken) |=> (mem[$past(u_idx)].ctr >= $past(u_old.ctr))); // R4

    AST_CTR_DOWN: assert property (@(posedge clk) disable iff (rst)
        (res.valid && u_hit && !res.taken) |=> (mem[$past(u_idx)].ctr <= $past(u_old.ctr))); // R4

endmodule

// File: rtl/btbp_resolve.sv
module btbp_resolve
    import btbp_pkg::*;
(
    input  resolve_t res,
    output logic     misp,
    output addr_t    restart
);

    logic dir_wrong;
    logic dst_wrong;

    assign dir_wrong = res.taken != res.pred_taken;
    assign dst_wrong = res.taken && res.pred_taken && (res.target != res.pred_target);
    assign misp      = res.valid && (dir_wrong || dst_wrong);
    assign restart   = res.taken ? res.target : res.next_pc;

endmodule

// File: rtl/btbp_qctl.sv
module btbp_qctl
    import btbp_pkg::*;
#(
    parameter int    QUEUE_BYTES = 32,
    parameter int    FETCH_BYTES = 8,
    parameter addr_t RESET_ADDR  = 32'h0000_1000,
    localparam int   LVL_W       = $clog2(QUEUE_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             steer,
    input  addr_t            steer_target,
    input  logic             misp,
    input  addr_t            restart,
    input  logic             dec_take,
    input  logic             req_ready,
    output logic             req_valid,
    output addr_t            req_addr,
    output logic             req_q,
    output logic             act_q,
    output logic [LVL_W-1:0] lvl0,
    output logic [LVL_W-1:0] lvl1
);

    localparam logic [LVL_W-1:0] CHUNK    = LVL_W'(FETCH_BYTES);
    localparam logic [LVL_W-1:0] ROOM_MAX = LVL_W'(QUEUE_BYTES - FETCH_BYTES);
    localparam addr_t            CHUNK_A  = ADDR_W'(FETCH_BYTES);

    logic [LVL_W-1:0] lvl  [2];
    addr_t            fptr [2];
    logic             act_r;
    logic             push;
    logic             pop;

    assign req_valid = lvl[act_r] <= ROOM_MAX;
    assign req_addr  = fptr[act_r];
    assign req_q     = act_r;
    assign act_q     = act_r;
    assign push      = req_valid && req_ready;
    assign pop       = dec_take && (lvl[act_r] >= CHUNK);
    assign lvl0      = lvl[0];
    assign lvl1      = lvl[1];

    always_ff @(posedge clk) begin
        if (rst)                 act_r <= 1'b0;
        else if (steer && !misp) act_r <= ~act_r;
    end

    for (genvar g = 0; g < 2; g++) begin : g_q
        logic [LVL_W-1:0] lvl_r;
        addr_t            fptr_r;
        logic             is_act;

        assign is_act  = (act_r == 1'(g));
        assign lvl[g]  = lvl_r;
        assign fptr[g] = fptr_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                lvl_r  <= '0;
                fptr_r <= (g == 0) ? RESET_ADDR : '0;
            end else if (misp) begin
                lvl_r <= '0;
                if (is_act) fptr_r <= restart;
            end else if (steer) begin
                if (!is_act) begin
                    lvl_r  <= '0;
                    fptr_r <= steer_target;
                end
            end else if (is_act) begin
                lvl_r  <= lvl_r + (push ? CHUNK : '0) - (pop ? CHUNK : '0);
                fptr_r <= fptr_r + (push ? CHUNK_A : '0);
            end
        end

        AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
            lvl_r <= LVL_W'(QUEUE_BYTES)); // R9

        AST_MISP_FLUSH: assert property (@(posedge clk) disable iff (rst)
            misp |=> (lvl_r == '0)); // R8
    end

    AST_STEER_SWAP: assert property (@(posedge clk) disable iff (rst)
        (steer && !misp) |=> (act_r != $past(act_r))); // R7

    AST_MISP_HOLD: assert property (@(posedge clk) disable iff (rst)
        misp |=> $stable(act_r)); // R8

    AST_PUSH_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (push && !misp && !steer) |=> (req_addr == $past(req_addr) + CHUNK_A)); // R9

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
    import btbp_pkg::*;
#(
    parameter int    QUEUE_BYTES = 32,
    parameter int    FETCH_BYTES = 8,
    parameter addr_t RESET_ADDR  = 32'h0000_1000
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             lk_valid,
    input  logic [31:0]                      lk_pc,
    output logic                             pred_hit,
    output logic                             pred_taken,
    output logic [31:0]                      pred_target,
    input  logic                             upd_valid,
    input  logic [31:0]                      upd_pc,
    input  logic                             upd_taken,
    input  logic [31:0]                      upd_target,
    input  logic [31:0]                      upd_next_pc,
    input  logic                             upd_pred_taken,
    input  logic [31:0]                      upd_pred_target,
    output logic                             mispredict,
    input  logic                             dec_take,
    output logic                             fetch_req_valid,
    input  logic                             fetch_req_ready,
    output logic [31:0]                      fetch_req_addr,
    output logic                             fetch_req_q,
    output logic                             active_q,
    output logic [$clog2(QUEUE_BYTES+1)-1:0] q0_level,
    output logic [$clog2(QUEUE_BYTES+1)-1:0] q1_level
);

    localparam int LVL_W = $clog2(QUEUE_BYTES + 1);

    resolve_t res;
    pred_t    pred;
    addr_t    restart;
    logic     misp;

    always_comb begin
        res.valid       = upd_valid;
        res.pc          = upd_pc;
        res.taken       = upd_taken;
        res.target      = upd_target;
        res.next_pc     = upd_next_pc;
        res.pred_taken  = upd_pred_taken;
        res.pred_target = upd_pred_target;
    end

    btbp_table u_table (
        .clk      (clk),
        .rst      (rst),
        .lk_valid (lk_valid),
        .lk_pc    (lk_pc),
        .pred     (pred),
        .res      (res)
    );

    btbp_resolve u_resolve (
        .res     (res),
        .misp    (misp),
        .restart (restart)
    );

    btbp_qctl #(
        .QUEUE_BYTES (QUEUE_BYTES),
        .FETCH_BYTES (FETCH_BYTES),
        .RESET_ADDR  (RESET_ADDR)
    ) u_qctl (
        .clk          (clk),
        .rst          (rst),
        .steer        (pred.taken),
        .steer_target (pred.target),
        .misp         (misp),
        .restart      (restart),
        .dec_take     (dec_take),
        .req_ready    (fetch_req_ready),
        .req_valid    (fetch_req_valid),
        .req_addr     (fetch_req_addr),
        .req_q        (fetch_req_q),
        .act_q        (active_q),
        .lvl0         (q0_level),
        .lvl1         (q1_level)
    );

    assign pred_hit    = pred.hit;
    assign pred_taken  = pred.taken;
    assign pred_target = pred.target;
    assign mispredict  = misp;

    AST_MISS_NO_TARGET: assert property (@(posedge clk) disable iff (rst)
        !pred_hit |-> (pred_target == '0 && !pred_taken)); // R2

    AST_LEVEL_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (q0_level <= LVL_W'(QUEUE_BYTES)) && (q1_level <= LVL_W'(QUEUE_BYTES))); // R9

endmodule

// File: tb/sim_btb_predictor.sv
`timescale 1ns/1ps
module sim_btb_predictor;

    logic        clk = 1'b0;
    logic        rst;
    logic        lk_valid;
    logic [31:0] lk_pc;
    logic        pred_hit, pred_taken;
    logic [31:0] pred_target;
    logic        upd_valid, upd_taken, upd_pred_taken;
    logic [31:0] upd_pc, upd_target, upd_next_pc, upd_pred_target;
    logic        mispredict;
    logic        dec_take;
    logic        fetch_req_valid, fetch_req_ready, fetch_req_q, active_q;
    logic [31:0] fetch_req_addr;
    logic [5:0]  q0_level, q1_level;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    btb_predictor u0 (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc),
        .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_target(pred_target),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target), .upd_next_pc(upd_next_pc),
        .upd_pred_taken(upd_pred_taken), .upd_pred_target(upd_pred_target),
        .mispredict(mispredict), .dec_take(dec_take),
        .fetch_req_valid(fetch_req_valid), .fetch_req_ready(fetch_req_ready),
        .fetch_req_addr(fetch_req_addr), .fetch_req_q(fetch_req_q),
        .active_q(active_q), .q0_level(q0_level), .q1_level(q1_level)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        lk_valid = 0; lk_pc = '0;
        upd_valid = 0; upd_pc = '0; upd_taken = 0; upd_target = '0;
        upd_next_pc = '0; upd_pred_taken = 0; upd_pred_target = '0;
        dec_take = 0; fetch_req_ready = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    task automatic look(input logic [31:0] pc, output logic hit, output logic tk,
                        output logic [31:0] tg);
        @(negedge clk);
        lk_valid = 1; lk_pc = pc;
        #1;
        hit = pred_hit; tk = pred_taken; tg = pred_target;
        @(negedge clk);
        lk_valid = 0;
    endtask

    task automatic upd(input logic [31:0] pc, input logic tk, input logic [31:0] tg,
                       input logic ptk, input logic [31:0] ptg, output logic mp);
        @(negedge clk);
        upd_valid = 1; upd_pc = pc; upd_taken = tk; upd_target = tg;
        upd_next_pc = pc + 32'd4; upd_pred_taken = ptk; upd_pred_target = ptg;
        #1;
        mp = mispredict;
        @(negedge clk);
        upd_valid = 0;
    endtask

    task automatic t_reset();
        logic h, t; logic [31:0] g;
        do_reset();
        chk("R1 active_q", active_q, 0);
        chk("R1 q0_level", q0_level, 0);
        chk("R1 q1_level", q1_level, 0);
        chk("R1 fetch addr", fetch_req_addr, 32'h1000);
        chk("R9 req valid when empty", fetch_req_valid, 1);
        look(32'h100, h, t, g);
        chk("R1 R2 miss hit", h, 0);
        chk("R2 miss taken", t, 0);
    endtask

    task automatic t_counter();
        logic h, t, mp; logic [31:0] g;
        do_reset();
        upd(32'h100, 1, 32'h2000, 0, 0, mp);
        chk("R8 misp on missed taken", mp, 1);
        look(32'h100, h, t, g);
        chk("R3 alloc hit", h, 1);
        chk("R3 alloc taken", t, 1);
        chk("R3 alloc target", g, 32'h2000);
        upd(32'h100, 0, 0, 1, 32'h2000, mp);          // 2 -> 1
        look(32'h100, h, t, g);
        chk("R4 weak nt", t, 0);
        chk("R4 still hit", h, 1);
        upd(32'h100, 1, 32'h2000, 0, 0, mp);          // 1 -> 2
        upd(32'h100, 1, 32'h2000, 1, 32'h2000, mp);   // 2 -> 3
        chk("R8 correct no misp", mp, 0);
        upd(32'h100, 0, 0, 1, 32'h2000, mp);          // 3 -> 2
        look(32'h100, h, t, g);
        chk("R4 hysteresis taken", t, 1);
        upd(32'h100, 0, 0, 1, 32'h2000, mp);          // 2 -> 1
        upd(32'h100, 0, 0, 0, 0, mp);                 // 1 -> 0
        upd(32'h100, 0, 0, 0, 0, mp);                 // stays 0
        upd(32'h100, 1, 32'h2000, 0, 0, mp);          // 0 -> 1
        look(32'h100, h, t, g);
        chk("R4 floor saturation", t, 0);
        upd(32'h100, 1, 32'h2000, 0, 0, mp);          // 1 -> 2
        look(32'h100, h, t, g);
        chk("R4 back to taken", t, 1);
    endtask

    task automatic t_alias();
        logic h, t, mp; logic [31:0] g;
        look(32'h0001_0100, h, t, g);
        chk("R5 tag mismatch miss", h, 0);
        upd(32'h0001_0100, 1, 32'h3000, 0, 0, mp);
        look(32'h100, h, t, g);
        chk("R5 old entry evicted", h, 0);
        look(32'h0001_0100, h, t, g);
        chk("R5 new entry target", g, 32'h3000);
        upd(32'h200, 0, 0, 1, 32'h9999, mp);
        look(32'h200, h, t, g);
        chk("R11 nt miss no alloc", h, 0);
    endtask

    task automatic t_bypass();
        do_reset();
        @(negedge clk);
        upd_valid = 1; upd_pc = 32'h300; upd_taken = 1; upd_target = 32'h4000;
        upd_next_pc = 32'h304; upd_pred_taken = 1; upd_pred_target = 32'h4000;
        lk_valid = 1; lk_pc = 32'h300;
        #1;
        chk("R6 forwarded taken", pred_taken, 1);
        chk("R6 forwarded target", pred_target, 32'h4000);
        @(negedge clk);
        upd_valid = 0; lk_valid = 0;
    endtask

    task automatic t_steer_fill();
        logic h, t, mp; logic [31:0] g;
        do_reset();
        upd(32'h400, 1, 32'h5000, 1, 32'h5000, mp);
        chk("R8 trained no misp", mp, 0);
        @(negedge clk); fetch_req_ready = 1;
        @(negedge clk);
        @(negedge clk); fetch_req_ready = 0;
        chk("R9 q0 level after 2", q0_level, 16);
        chk("R9 q0 addr after 2", fetch_req_addr, 32'h1010);
        look(32'h400, h, t, g);
        chk("R7 active toggled", active_q, 1);
        chk("R7 new queue empty", q1_level, 0);
        chk("R7 fetch from target", fetch_req_addr, 32'h5000);
        chk("R7 request queue", fetch_req_q, 1);
        chk("R7 old queue kept", q0_level, 16);
        @(negedge clk); fetch_req_ready = 1;
        for (int i = 0; i < 6; i++) @(negedge clk);
        fetch_req_ready = 0;
        chk("R9 full level", q1_level, 32);
        chk("R9 no req when full", fetch_req_valid, 0);
        chk("R9 addr after fill", fetch_req_addr, 32'h5020);
        @(negedge clk); dec_take = 1;
        @(negedge clk); dec_take = 0;
        chk("R10 take removes chunk", q1_level, 24);
        @(negedge clk); dec_take = 1; fetch_req_ready = 1;
        @(negedge clk); dec_take = 0; fetch_req_ready = 0;
        chk("R10 take plus push level", q1_level, 24);
        chk("R9 take plus push addr", fetch_req_addr, 32'h5028);
    endtask

    task automatic t_mispredict();
        @(negedge clk);
        upd_valid = 1; upd_pc = 32'h700; upd_taken = 0; upd_target = 0;
        upd_next_pc = 32'h6000; upd_pred_taken = 1; upd_pred_target = 32'h7777;
        lk_valid = 1; lk_pc = 32'h400;
        #1;
        chk("R8 misp asserted", mispredict, 1);
        @(negedge clk);
        upd_valid = 0; lk_valid = 0;
        chk("R8 active unchanged", active_q, 1);
        chk("R8 q0 flushed", q0_level, 0);
        chk("R8 q1 flushed", q1_level, 0);
        chk("R8 restart addr", fetch_req_addr, 32'h6000);
        @(negedge clk); dec_take = 1;
        @(negedge clk); dec_take = 0;
        chk("R10 take on empty ignored", q1_level, 0);
    endtask

    initial begin
        rst = 1;
        idle_inputs();
        t_reset();
        t_counter();
        t_alias();
        t_bypass();
        t_steer_fill();
        t_mispredict();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule